// File: doc/BRIEF.md
# Virtual Address Translation Unit

This unit maps a 14-bit virtual address onto a 12-bit physical address. The top eight bits of the virtual address name a virtual page and the low six bits are a byte offset that passes through unchanged. A translation buffer holds recent page mappings. It has four sets of four ways. The set is picked by the two low page bits, and the six upper page bits are kept as the tag. When the buffer holds no matching entry, the unit reads one entry from a single-level page table through a simple read port. It then reports the result and, when the entry is usable, installs it in the buffer.

Every finished translation produces a one-cycle result pulse. The pulse carries the physical address, whether the buffer supplied the mapping, a page-fault flag for an absent page, and a protection flag. The protection flag is raised when the request type (read or write) is not allowed by the page's access code. A flush input empties the buffer in a single clock.

Top module: `vat_unit`

## Requirements
- R1: The result address is the 6-bit physical page number in bits 11:6, with bits 5:0 equal to virtual address bits 5:0. The set index is virtual address bits 7:6 and the tag is bits 13:8.
- R2: A request whose page is resident gives `done` with `done_hit`=1 two clocks after the request is accepted, and issues no table read.
- R3: A request that misses pulses `pt_rd_en` for one clock with `pt_rd_addr` equal to virtual address bits 13:6. `done` (with `done_hit`=0) follows one clock after the clock in which `pt_rd_valid` is high.
- R4: A table entry has valid in bit 8, the access code in bits 7:6 and the physical page in bits 5:0. An entry with bit 8 clear gives `done_fault`=1, `done_paddr`=0, `done_hit`=0 and `done_prot_err`=0, and it is not installed, so a repeat request reads the table again.
- R5: A fetched entry with bit 8 set is installed, so the next request to that page hits.
- R6: Access code 2'b10 allows reads and writes. 2'b01 allows reads only, so a write raises `done_prot_err`. 2'b00, and the reserved 2'b11, raise `done_prot_err` for any access. The address is still returned.
- R7: A refill fills the lowest-numbered invalid way of the set. When all four ways are valid, it replaces the way named by that set's rotating pointer, which starts at way 0 and advances by one after each such replacement.
- R8: A one-clock `flush` pulse invalidates every entry. If a refill falls in the same clock, the flush wins.
- R9: `req_ready` is high only while the unit is idle. A request is accepted when `req_valid` and `req_ready` are both high. Each accepted request yields exactly one single-clock `done` pulse.
- R10: After reset `done`=0, `pt_rd_en`=0, `req_ready`=1, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle, request can be accepted |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| flush | input | 1 | Invalidate all buffer entries |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_rd_addr | output | 8 | Page-table index (virtual page number) |
| pt_rd_valid | input | 1 | Page-table read data valid |
| pt_rd_data | input | 9 | Page-table entry {valid, access code, page} |
| done | output | 1 | Result pulse |
| done_paddr | output | 12 | Physical address |
| done_hit | output | 1 | Mapping came from the buffer |
| done_fault | output | 1 | Page not present |
| done_prot_err | output | 1 | Access not permitted |

## Verification
The bench fills one set past its capacity and then revisits pages. A design with a wrong victim choice or a stuck rotating pointer would hit where a miss is due, or miss where a hit is due. It sends absent pages twice in a row, which exposes a design that caches faulting entries: it would answer the second request as a hit. Reads and writes are sent to pages of each access code, including the reserved one, so a swapped code or an unflagged write to a read-only page shows up in `done_prot_err`. Flush, table-read counts and result latency are checked too. A design that drops a flush or walks the table on a hit is caught by a wrong hit flag, a wrong read count or a shifted `done`.

// File: rtl/vat_pkg.sv
package vat_pkg;
    localparam int VA_W   = 14;
    localparam int OFF_W  = 6;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 6;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int N_SETS = 4;
    localparam int N_WAYS = 4;
    localparam int SET_W  = $clog2(N_SETS);
    localparam int WAY_W  = $clog2(N_WAYS);
    localparam int TAG_W  = VPN_W - SET_W;
    localparam int PTE_W  = 1 + 2 + PPN_W;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_RW   = 2'b10,
        ACC_RSVD = 2'b11
    } access_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        access_e           acc;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2
    } fsm_e;
endpackage

// File: rtl/vat_access_check.sv
module vat_access_check
    import vat_pkg::*;
(
    input  access_e acc,
    input  logic    is_write,
    output logic    violation
);
    always_comb begin
        case (acc)
            ACC_RW:  violation = 1'b0;
            ACC_RO:  violation = is_write;
            default: violation = 1'b1;
        endcase
    end
endmodule

// File: rtl/vat_victim.sv
module vat_victim
    import vat_pkg::*;
#(
    parameter int SETS = N_SETS,
    parameter int WAYS = N_WAYS,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   set_idx,
    input  logic [WAYS-1:0] valid_mask,
    input  logic            replace,
    output logic [WW-1:0]   victim,
    output logic            set_full
);
    logic [WW-1:0] ptr_q [SETS];
    logic [WW-1:0] ptr_d [SETS];
    logic [WW-1:0] free_way;
    logic          have_free;

    always_comb begin
        free_way  = '0;
        have_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_mask[w]) begin
                free_way  = WW'(w);
                have_free = 1'b1;
            end
        end
        set_full = !have_free;
        victim   = have_free ? free_way : ptr_q[set_idx];
    end

    always_comb begin
        for (int s = 0; s < SETS; s++) ptr_d[s] = ptr_q[s];
        if (replace && set_full) ptr_d[set_idx] = ptr_q[set_idx] + WW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= ptr_d[s];
        end
    end
endmodule

// File: rtl/vat_tlb_array.sv
module vat_tlb_array
    import vat_pkg::*;
#(
    parameter int SETS = N_SETS,
    parameter int WAYS = N_WAYS,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SW-1:0]    lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output access_e          lk_acc,
    output logic [WAYS-1:0]  lk_valid,
    input  logic             wr_en,
    input  logic [WW-1:0]    wr_way,
    input  tlb_entry_t       wr_entry
);
    tlb_entry_t      ent_q [SETS][WAYS];
    tlb_entry_t      ent_d [SETS][WAYS];
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w]    = ent_q[lk_set][w].valid && (ent_q[lk_set][w].tag == lk_tag);
        assign lk_valid[w] = ent_q[lk_set][w].valid;
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_acc = ACC_NONE;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                lk_hit = 1'b1;
                lk_ppn = ent_q[lk_set][w].ppn;
                lk_acc = ent_q[lk_set][w].acc;
            end
        end
    end

    always_comb begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                ent_d[s][w] = ent_q[s][w];
        if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_d[s][w].valid = 1'b0;
        end else if (wr_en) begin
            ent_d[lk_set][wr_way] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_q[s][w] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_q[s][w] <= ent_d[s][w];
        end
    end
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              flush,
    output logic              pt_rd_en,
    output logic [VPN_W-1:0]  pt_rd_addr,
    input  logic              pt_rd_valid,
    input  logic [PTE_W-1:0]  pt_rd_data,
    output logic              done,
    output logic [PA_W-1:0]   done_paddr,
    output logic              done_hit,
    output logic              done_fault,
    output logic              done_prot_err
);
    typedef struct packed {
        fsm_e             fsm;
        logic [VA_W-1:0]  vaddr;
        logic             wr;
        logic             done;
        logic [PA_W-1:0]  paddr;
        logic             hit;
        logic             fault;
        logic             perr;
        logic             rd_en;
        logic [VPN_W-1:0] rd_addr;
    } state_t;

    state_t st_q, st_d;

    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic [OFF_W-1:0]  off;
    logic              tlb_hit;
    logic [PPN_W-1:0]  tlb_ppn;
    access_e           tlb_acc;
    logic [N_WAYS-1:0] tlb_valid;
    logic [WAY_W-1:0]  victim;
    logic              set_full;
    logic              refill_d;
    tlb_entry_t        refill_entry;
    logic              pte_valid;
    access_e           pte_acc;
    logic [PPN_W-1:0]  pte_ppn;
    access_e           chk_acc;
    logic              violation;

    assign lk_set    = st_q.vaddr[OFF_W +: SET_W];
    assign lk_tag    = st_q.vaddr[VA_W-1 -: TAG_W];
    assign off       = st_q.vaddr[OFF_W-1:0];
    assign pte_valid = pt_rd_data[PTE_W-1];
    assign pte_acc   = access_e'(pt_rd_data[PPN_W +: 2]);
    assign pte_ppn   = pt_rd_data[PPN_W-1:0];
    assign chk_acc   = (st_q.fsm == ST_LOOK) ? tlb_acc : pte_acc;

    vat_tlb_array #(.SETS(N_SETS), .WAYS(N_WAYS)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_set   (lk_set),
        .lk_tag   (lk_tag),
        .lk_hit   (tlb_hit),
        .lk_ppn   (tlb_ppn),
        .lk_acc   (tlb_acc),
        .lk_valid (tlb_valid),
        .wr_en    (refill_d),
        .wr_way   (victim),
        .wr_entry (refill_entry)
    );

    vat_victim #(.SETS(N_SETS), .WAYS(N_WAYS)) i_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (lk_set),
        .valid_mask (tlb_valid),
        .replace    (refill_d && !flush),
        .victim     (victim),
        .set_full   (set_full)
    );

    vat_access_check i_access (
        .acc       (chk_acc),
        .is_write  (st_q.wr),
        .violation (violation)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.rd_en   = 1'b0;
        refill_d     = 1'b0;
        refill_entry = '{valid: 1'b1, tag: lk_tag, ppn: pte_ppn, acc: pte_acc};
        case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.vaddr = req_vaddr;
                    st_d.wr    = req_write;
                    st_d.fsm   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (tlb_hit) begin
                    st_d.done  = 1'b1;
                    st_d.hit   = 1'b1;
                    st_d.fault = 1'b0;
                    st_d.perr  = violation;
                    st_d.paddr = {tlb_ppn, off};
                    st_d.fsm   = ST_IDLE;
                end else begin
                    st_d.rd_en   = 1'b1;
                    st_d.rd_addr = st_q.vaddr[VA_W-1 -: VPN_W];
                    st_d.fsm     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (pt_rd_valid) begin
                    st_d.done = 1'b1;
                    st_d.hit  = 1'b0;
                    st_d.fsm  = ST_IDLE;
                    if (pte_valid) begin
                        st_d.fault = 1'b0;
                        st_d.perr  = violation;
                        st_d.paddr = {pte_ppn, off};
                        refill_d   = 1'b1;
                    end else begin
                        st_d.fault = 1'b1;
                        st_d.perr  = 1'b0;
                        st_d.paddr = '0;
                    end
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready     = (st_q.fsm == ST_IDLE);
    assign pt_rd_en      = st_q.rd_en;
    assign pt_rd_addr    = st_q.rd_addr;
    assign done          = st_q.done;
    assign done_paddr    = st_q.paddr;
    assign done_hit      = st_q.hit;
    assign done_fault    = st_q.fault;
    assign done_prot_err = st_q.perr;

    logic unused_full;
    assign unused_full = set_full;
endmodule

// File: rtl/vat_unit_chk.sv
module vat_unit_chk
    import vat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              req_write,
    input logic              flush,
    input logic              pt_rd_en,
    input logic [VPN_W-1:0]  pt_rd_addr,
    input logic              pt_rd_valid,
    input logic [PTE_W-1:0]  pt_rd_data,
    input logic              done,
    input logic [PA_W-1:0]   done_paddr,
    input logic              done_hit,
    input logic              done_fault,
    input logic              done_prot_err
);
    logic [OFF_W-1:0] cap_off;
    logic             read_seen;
    logic             waiting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_off   <= '0;
            read_seen <= 1'b0;
            waiting   <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                cap_off   <= req_vaddr[OFF_W-1:0];
                read_seen <= 1'b0;
            end
            if (pt_rd_en) begin
                read_seen <= 1'b1;
                waiting   <= 1'b1;
            end else if (pt_rd_valid) begin
                waiting   <= 1'b0;
            end
        end
    end

    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault |-> done_paddr[OFF_W-1:0] == cap_off);

    p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_hit |-> !read_seen);

    p_done_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && pt_rd_valid |=> done && !done_hit);

    p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault |-> !done_hit && done_paddr == '0 && !done_prot_err);

    p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |=> !pt_rd_en);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !req_ready);
endmodule

bind vat_unit vat_unit_chk i_chk (.*);

// File: tb/test_vat_unit.sv
module test_vat_unit;
    localparam int MEM_LAT = 2;
    localparam int NVEC    = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        flush = 1'b0;
    logic        pt_rd_en;
    logic [7:0]  pt_rd_addr;
    logic        pt_rd_valid = 1'b0;
    logic [8:0]  pt_rd_data = '0;
    logic        done;
    logic [11:0] done_paddr;
    logic        done_hit, done_fault, done_prot_err;

    int n_chk = 0;
    int n_fail = 0;
    int reads = 0;
    int rsp_cnt = -1;
    int cycles = 0;
    logic [7:0] last_rd_addr = '0;
    logic [7:0] rsp_addr = '0;

    always #4 clk = ~clk;

    vat_unit i_vat_unit (.*);

    // {vaddr[29:16], write[15], paddr[14:3], hit[2], fault[1], prot_err[0]}
    localparam logic [29:0] VEC [NVEC] = '{
        {14'h0045, 1'b0, 12'hAC5, 1'b0, 1'b0, 1'b0},
        {14'h007F, 1'b1, 12'hAFF, 1'b1, 1'b0, 1'b0},
        {14'h0240, 1'b1, 12'h8C0, 1'b0, 1'b0, 1'b1},
        {14'h0250, 1'b0, 12'h8D0, 1'b1, 1'b0, 1'b0},
        {14'h01C0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b0},
        {14'h01C0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b0},
        {14'h0481, 1'b0, 12'hE01, 1'b0, 1'b0, 1'b1},
        {14'h0481, 1'b0, 12'hE01, 1'b1, 1'b0, 1'b1},
        {14'h0342, 1'b0, 12'h9C2, 1'b0, 1'b0, 1'b0},
        {14'h0144, 1'b1, 12'hBC4, 1'b0, 1'b0, 1'b0},
        {14'h0648, 1'b0, 12'hCC8, 1'b0, 1'b0, 1'b1},
        {14'h0240, 1'b0, 12'h8C0, 1'b1, 1'b0, 1'b0},
        {14'h0040, 1'b0, 12'hAC0, 1'b0, 1'b0, 1'b0},
        {14'h0240, 1'b0, 12'h8C0, 1'b0, 1'b0, 1'b0},
        {14'h0340, 1'b0, 12'h9C0, 1'b0, 1'b0, 1'b0},
        {14'h0648, 1'b0, 12'hCC8, 1'b1, 1'b0, 1'b1},
        {14'h307F, 1'b1, 12'hAFF, 1'b0, 1'b0, 1'b0},
        {14'h0648, 1'b0, 12'hCC8, 1'b0, 1'b0, 1'b1}
    };

    // Page-table model: low page bits 111 absent; bits 4:3 pick the access code.
    function automatic logic [8:0] pte(input logic [7:0] v);
        logic [1:0] acc;
        case (v[4:3])
            2'd0:    acc = 2'b10;
            2'd1:    acc = 2'b01;
            2'd2:    acc = 2'b00;
            default: acc = 2'b11;
        endcase
        return {(v[2:0] != 3'd7), acc, v[5:0] ^ 6'h2A};
    endfunction

    always @(negedge clk) begin
        cycles++;
        pt_rd_valid = 1'b0;
        if (rsp_cnt == 0) begin
            pt_rd_valid = 1'b1;
            pt_rd_data  = pte(rsp_addr);
            rsp_cnt     = -1;
        end else if (rsp_cnt > 0) begin
            rsp_cnt--;
        end
        if (pt_rd_en) begin
            rsp_addr     = pt_rd_addr;
            last_rd_addr = pt_rd_addr;
            rsp_cnt      = MEM_LAT - 1;
            reads++;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        while (cycles < 100000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic txn(input logic [13:0] va, input logic wr, input logic [11:0] ep,
                       input logic eh, input logic ef, input logic epe);
        int cyc;
        int r0;
        @(negedge clk);
        r0 = reads;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        chk(req_ready == 1'b0, "R9 busy not ready", int'(req_ready), 0);
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R9 done pulse", int'(done), 1);
        chk(done_paddr == ep, "R1 paddr", int'(done_paddr), int'(ep));
        chk(done_hit == eh, "R2/R5/R7 hit", int'(done_hit), int'(eh));
        chk(done_fault == ef, "R4 fault", int'(done_fault), int'(ef));
        chk(done_prot_err == epe, "R6 prot", int'(done_prot_err), int'(epe));
        if (eh) begin
            chk(cyc == 2, "R2 hit latency", cyc, 2);
            chk(reads == r0, "R2 no table read", reads - r0, 0);
        end else begin
            chk(cyc == 3 + MEM_LAT, "R3 miss latency", cyc, 3 + MEM_LAT);
            chk(reads == r0 + 1, "R3 one table read", reads - r0, 1);
            chk(last_rd_addr == va[13:6], "R3 read addr", int'(last_rd_addr), int'(va[13:6]));
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10 reset done", int'(done), 0);
        chk(pt_rd_en == 1'b0, "R10 reset rd_en", int'(pt_rd_en), 0);
        chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 idle ready", int'(req_ready), 1);

        for (int i = 0; i < NVEC; i++)
            txn(VEC[i][29:16], VEC[i][15], VEC[i][14:3], VEC[i][2], VEC[i][1], VEC[i][0]);

        // R8: a resident page misses after a flush, then hits after refill (R5)
        txn(14'h307F, 1'b0, 12'hAFF, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        txn(14'h307F, 1'b0, 12'hAFF, 1'b0, 1'b0, 1'b0);
        txn(14'h3040, 1'b1, 12'hAC0, 1'b1, 1'b0, 1'b0);
        // R10 style: an empty buffer after flush misses on another set too
        txn(14'h0481, 1'b1, 12'hE01, 1'b0, 1'b0, 1'b1);

        finish_run();
    end
endmodule